// File: doc/BRIEF.md
# Bus Clock Speed Calibrator

The calibrator measures an unknown bus clock against its own reference clock, whose period is known. The bus-clock side supplies a square wave: its frequency is the bus clock divided down, first by a fixed tick divider (`TICK_DIV` bus clocks per tick, 520 by default) and then by a half-period count (`HALF_CNT`, 63 by default). One full square-wave cycle therefore lasts `2*(HALF_CNT+1)` ticks. The square wave reaches the block asynchronously. A start strobe arms a measurement. The block takes a timestamp from a free-running reference-cycle counter on two chosen rising edges of the wave. From the window between the two timestamps it computes the length of one divider tick in nanoseconds.

The result is kept as nanoseconds per tick, not per bus clock, so that no precision is lost. Dividing it by `TICK_DIV` gives the bus clock period. The result is checked against a plausible bus-frequency range of 25 to 75 MHz. A result outside that range is replaced by the tick length of a 66 MHz bus, and the valid flag is cleared. The block also sorts the bus into one of two classes: fast (66 MHz) or slow (33 MHz). All range and class limits are turned into reference-cycle counts at elaboration time, so the only arithmetic block in the datapath is a small serial divider that produces the reported period.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The outputs are registered and hold their value until the next start strobe.

Top module: `busclk_calibrator`

## Requirements
- R1: Only a low-to-high change of the synchronized wave counts as an edge. After reset or start, the previous-level register is 1, so a wave that is already high when start arrives is not counted until a low sample has been seen.
- R2: The first `DISCARD` (default 2) rising edges are warm-up. The window opens with a timestamp taken on rising edge number `DISCARD`, so irregular spacing before that edge has no effect on the result.
- R3: The window closes on rising edge number `DISCARD+CYCLES` (default 258). The raw result is floor(window_ref_cycles * REF_PS / (1000 * CYCLES * 2*(HALF_CNT+1))) nanoseconds per tick. `done_o` rises once the result is ready.
- R4: A raw result above floor(1000*TICK_DIV/25) ns means a bus slower than 25 MHz. In that case the reported period is the default and `valid_o` is 0.
- R5: A raw result below floor(1000*TICK_DIV/75) ns means a bus faster than 75 MHz. In that case the reported period is the default and `valid_o` is 0. A raw result inside both bounds is reported unchanged with `valid_o` = 1.
- R6: The default period is floor(1000*TICK_DIV/66) ns per tick (7878 for TICK_DIV = 520).
- R7: `fast_o` = 1 when the reported period divided by TICK_DIV is below 20 ns, that is, when period < 20*TICK_DIV. Otherwise `fast_o` = 0. This rule also applies to the substituted default.
- R8: A start pulse clears the edge counter, both timestamps, `done_o` and `valid_o`, and restarts the measurement even while one is in progress. The last start pulse decides the window.
- R9: After reset, `done_o`, `valid_o`, `fast_o` and `period_o` are all 0.
- R10: While `done_o` is high and no start arrives, `done_o`, `period_o`, `valid_o` and `fast_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock of known period REF_PS picoseconds |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that arms a new measurement |
| wave_i | input | 1 | Asynchronous square wave derived from the bus clock |
| done_o | output | 1 | Result ready; held until the next start |
| period_o | output | PER_W | Nanoseconds per divider tick (measured or default) |
| valid_o | output | 1 | 1 when the measured value passed both range checks |
| fast_o | output | 1 | 1 for the fast (66 MHz) class, 0 for the slow (33 MHz) class |

## Verification
Several rules are checked on every cycle: the result holds stable while done is high, a start pulse drops done on the next cycle, a valid result lies inside the frequency bounds, an invalid result equals the default, and the class bit matches the reported period. Edge selection can only be shown by the bench scenarios. These cover warm-up spacing that differs from the measured spacing, a wave that is already high when start arrives, and a restart in the middle of a window. The exact boundary values on both sides of each limit are also bench-only, since they depend on the window length actually counted.

// File: rtl/busclk_cal_pkg.sv
package busclk_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEAS,
    ST_DIV,
    ST_DONE
  } cal_state_e;

  // Integer ceiling division used to fold limits into reference-cycle counts
  function automatic longint ceil_div(input longint num, input longint den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/bcal_sync.sv
module bcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bcal_window.sv
module bcal_window #(
  parameter int TS_W    = 32,
  parameter int DISCARD = 2,
  parameter int CYCLES  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            lvl_i,
  output logic            fin_o,
  output logic [TS_W-1:0] span_o
);

  localparam int LAST_EDGE = DISCARD + CYCLES;
  localparam int CNT_W     = $clog2(LAST_EDGE + 1);

  logic [TS_W-1:0]  ts_q;
  logic [TS_W-1:0]  t_open_q;
  logic [TS_W-1:0]  t_close_q;
  logic [CNT_W-1:0] edges_q;
  logic             prev_q;
  logic             rise;

  // Free-running reference timestamp
  always_ff @(posedge clk) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  // Previous level starts high so a wave already high is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) prev_q <= 1'b1;
    else                 prev_q <= lvl_i;
  end

  assign rise = en_i && !prev_q && lvl_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      edges_q   <= '0;
      t_open_q  <= '0;
      t_close_q <= '0;
      fin_o     <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (rise && edges_q != CNT_W'(LAST_EDGE)) begin
        edges_q <= edges_q + 1'b1;
        if (edges_q == CNT_W'(DISCARD - 1)) t_open_q <= ts_q;
        if (edges_q == CNT_W'(LAST_EDGE - 1)) begin
          t_close_q <= ts_q;
          fin_o     <= 1'b1;
        end
      end
    end
  end

  assign span_o = t_close_q - t_open_q;

endmodule

// File: rtl/bcal_divider.sv
module bcal_divider #(
  parameter int N_W = 45,
  parameter int D_W = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort_i,
  input  logic           go_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic           done_o,
  output logic [N_W-1:0] quo_o
);

  localparam int IT_W = $clog2(N_W + 1);

  logic [D_W:0]    rem_q;
  logic [N_W-1:0]  quo_q;
  logic [IT_W-1:0] left_q;
  logic            busy_q;
  logic [D_W:0]    trial;
  logic            take;

  assign trial = {rem_q[D_W-1:0], quo_q[N_W-1]};
  assign take  = trial >= {1'b0, den_i};

  always_ff @(posedge clk) begin
    if (!rst_n || abort_i) begin
      rem_q  <= '0;
      quo_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        left_q <= IT_W'(N_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= take ? (trial - {1'b0, den_i}) : trial;
        quo_q  <= {quo_q[N_W-2:0], take};
        left_q <= left_q - 1'b1;
        if (left_q == IT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;

endmodule

// File: rtl/busclk_calibrator.sv
module busclk_calibrator
  import busclk_cal_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int PER_W       = 32,
  parameter int REF_PS      = 8000,
  parameter int TICK_DIV    = 520,
  parameter int HALF_CNT    = 63,
  parameter int CYCLES      = 256,
  parameter int DISCARD     = 2,
  parameter int LOW_MHZ     = 25,
  parameter int HIGH_MHZ    = 75,
  parameter int DEF_MHZ     = 66,
  parameter int CLASS_NS    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wave_i,
  output logic             done_o,
  output logic [PER_W-1:0] period_o,
  output logic             valid_o,
  output logic             fast_o
);

  // Divider constant: ps-to-ns scale times square-wave cycles times ticks per cycle
  localparam longint NORM      = 64'd1000 * longint'(CYCLES) * longint'(2 * (HALF_CNT + 1));
  localparam int     D_W       = $clog2(NORM + 1);
  localparam int     PS_W      = $clog2(REF_PS + 1);
  localparam int     DVD_W     = TS_W + PS_W;

  // Limits in nanoseconds per tick
  localparam longint LOW_LIM   = (64'd1000 * TICK_DIV) / LOW_MHZ;
  localparam longint HIGH_LIM  = (64'd1000 * TICK_DIV) / HIGH_MHZ;
  localparam longint DEF_NS    = (64'd1000 * TICK_DIV) / DEF_MHZ;
  localparam longint CLASS_LIM = longint'(CLASS_NS) * TICK_DIV;

  // Same limits folded into reference cycles over the whole window
  localparam logic [63:0] T_SLOW  = 64'(ceil_div((LOW_LIM + 1) * NORM, REF_PS));
  localparam logic [63:0] T_FAST  = 64'(ceil_div(HIGH_LIM * NORM, REF_PS));
  localparam logic [63:0] T_CLASS = 64'(ceil_div(CLASS_LIM * NORM, REF_PS));
  localparam bit          DEF_FAST = (DEF_NS < CLASS_LIM);
  localparam logic [DVD_W-1:0] PER_MAX = DVD_W'({PER_W{1'b1}});

  cal_state_e        st_q;
  logic              lvl;
  logic              win_fin;
  logic [TS_W-1:0]   span;
  logic [63:0]       span_w;
  logic              div_done;
  logic [DVD_W-1:0]  quo;
  logic [DVD_W-1:0]  num;
  logic [PER_W-1:0]  per_meas;
  logic              fail_q;
  logic              class_q;
  logic              out_of_range;
  logic              fast_win;

  bcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_i   (wave_i),
    .q_o   (lvl)
  );

  bcal_window #(
    .TS_W    (TS_W),
    .DISCARD (DISCARD),
    .CYCLES  (CYCLES)
  ) u_window (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .en_i   (st_q == ST_MEAS),
    .lvl_i  (lvl),
    .fin_o  (win_fin),
    .span_o (span)
  );

  assign num = DVD_W'(span) * DVD_W'(REF_PS);

  bcal_divider #(
    .N_W (DVD_W),
    .D_W (D_W)
  ) u_div (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .abort_i (start_i),
    .go_i    (win_fin && st_q == ST_MEAS),
    .num_i   (num),
    .den_i   (D_W'(NORM)),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  // Range and class decisions on the raw window length
  assign span_w       = 64'(span);
  assign out_of_range = (span_w >= T_SLOW) || (span_w < T_FAST);
  assign fast_win     = (span_w < T_CLASS);

  assign per_meas = (quo > PER_MAX) ? {PER_W{1'b1}} : quo[PER_W-1:0];

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done_o   <= 1'b0;
      period_o <= '0;
      valid_o  <= 1'b0;
      fast_o   <= 1'b0;
      fail_q   <= 1'b0;
      class_q  <= 1'b0;
    end else if (start_i) begin
      st_q    <= ST_MEAS;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      case (st_q)
        ST_MEAS: begin
          if (win_fin) begin
            st_q    <= ST_DIV;
            fail_q  <= out_of_range;
            class_q <= fast_win;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            st_q     <= ST_DONE;
            done_o   <= 1'b1;
            period_o <= fail_q ? PER_W'(DEF_NS) : per_meas;
            valid_o  <= !fail_q;
            fast_o   <= fail_q ? DEF_FAST : class_q;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/busclk_calibrator_chk.sv
module busclk_calibrator_chk #(
  parameter int PER_W    = 32,
  parameter int TICK_DIV = 520,
  parameter int LOW_MHZ  = 25,
  parameter int HIGH_MHZ = 75,
  parameter int DEF_MHZ  = 66,
  parameter int CLASS_NS = 20
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic [PER_W-1:0] period_o,
  input logic             valid_o,
  input logic             fast_o
);

  localparam longint LOW_LIM   = (64'd1000 * TICK_DIV) / LOW_MHZ;
  localparam longint HIGH_LIM  = (64'd1000 * TICK_DIV) / HIGH_MHZ;
  localparam longint DEF_NS    = (64'd1000 * TICK_DIV) / DEF_MHZ;
  localparam longint CLASS_LIM = longint'(CLASS_NS) * TICK_DIV;

  // R8: a start pulse drops done on the next cycle
  a_r8_start_clears_done: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start_i |=> !done_o);

  // R10: the result holds while done is high and no start arrives
  a_r10_result_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(period_o) && $stable(valid_o) && $stable(fast_o)));

  // R4 and R5: a valid result lies inside both bounds
  a_r5_valid_in_bounds: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done_o && valid_o) |-> (period_o >= PER_W'(HIGH_LIM) && period_o <= PER_W'(LOW_LIM)));

  // R6: an invalid result carries the default
  a_r6_default_value: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done_o && !valid_o) |-> (period_o == PER_W'(DEF_NS)));

  // R7: the class bit agrees with the reported period
  a_r7_class_matches: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done_o |-> (fast_o == (period_o < PER_W'(CLASS_LIM))));

endmodule

bind busclk_calibrator busclk_calibrator_chk #(
  .PER_W    (PER_W),
  .TICK_DIV (TICK_DIV),
  .LOW_MHZ  (LOW_MHZ),
  .HIGH_MHZ (HIGH_MHZ),
  .DEF_MHZ  (DEF_MHZ),
  .CLASS_NS (CLASS_NS)
) chk_i (
  .clk_ref  (clk_ref),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .done_o   (done_o),
  .period_o (period_o),
  .valid_o  (valid_o),
  .fast_o   (fast_o)
);

// File: tb/busclk_calibrator_tb_top.sv
`timescale 1ns/1ps
module busclk_calibrator_tb_top;

  localparam int PER_W  = 32;
  localparam int CYC    = 8;
  localparam int DISC   = 2;
  localparam int TICK   = 52;
  localparam int HALF   = 0;
  localparam int REF_PS = 8000;

  // Limits from the requirements (ns per tick)
  localparam longint LOW_NS   = 1000 * TICK / 25;
  localparam longint HIGH_NS  = 1000 * TICK / 75;
  localparam longint DEF_NS   = 1000 * TICK / 66;
  localparam longint CLASS_NS = 20 * TICK;

  typedef struct packed {
    int h;       // half period of the measured wave in reference cycles
    int w;       // half period of the warm-up edges
    bit pre_hi;  // wave already high when start arrives
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{120, 120, 1'b0},
    '{240, 240, 1'b0},
    '{87,  87,  1'b0},
    '{86,  86,  1'b0},
    '{129, 129, 1'b0},
    '{130, 130, 1'b0},
    '{260, 260, 1'b0},
    '{261, 261, 1'b0},
    '{100, 400, 1'b0},
    '{200, 30,  1'b0},
    '{150, 300, 1'b1}
  };

  logic             clk_ref = 1'b0;
  logic             rst_n   = 1'b0;
  logic             start_i = 1'b0;
  logic             wave_i  = 1'b0;
  logic             done_o;
  logic [PER_W-1:0] period_o;
  logic             valid_o;
  logic             fast_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #4 clk_ref = ~clk_ref;

  busclk_calibrator #(
    .TS_W     (32),
    .PER_W    (PER_W),
    .REF_PS   (REF_PS),
    .TICK_DIV (TICK),
    .HALF_CNT (HALF),
    .CYCLES   (CYC),
    .DISCARD  (DISC)
  ) dut_i (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .wave_i   (wave_i),
    .done_o   (done_o),
    .period_o (period_o),
    .valid_o  (valid_o),
    .fast_o   (fast_o)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk_ref) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Expected result from R3..R7 for a wave of half period h cycles
  task automatic expect_for(input int h, output longint per, output bit val, output bit fst);
    longint span, raw;
    span = longint'(CYC) * 2 * h;
    raw  = (span * REF_PS) / (1000 * CYC * 2 * (HALF + 1));
    if (raw > LOW_NS || raw < HIGH_NS) begin
      per = DEF_NS;
      val = 1'b0;
    end else begin
      per = raw;
      val = 1'b1;
    end
    fst = (per < CLASS_NS);
  endtask

  task automatic pulse_start();
    @(negedge clk_ref) start_i = 1'b1;
    @(negedge clk_ref) start_i = 1'b0;
  endtask

  // Warm-up edges at spacing w, then the steady wave at half period h
  task automatic measure(input int h, input int w, input bit pre_hi);
    wave_i = pre_hi;
    repeat (6) @(negedge clk_ref);
    pulse_start();
    if (pre_hi) repeat (50) @(negedge clk_ref);
    wave_i = 1'b0; repeat (w) @(negedge clk_ref);
    wave_i = 1'b1; repeat (w) @(negedge clk_ref);
    wave_i = 1'b0; repeat (w) @(negedge clk_ref);
    for (int k = 0; k < 200 && !done_o; k++) begin
      wave_i = 1'b1; repeat (h) @(negedge clk_ref);
      wave_i = 1'b0; repeat (h) @(negedge clk_ref);
    end
  endtask

  initial begin
    longint ep;
    bit ev, ef;
    repeat (4) @(negedge clk_ref);
    // R9: reset state
    check("R9", "done", done_o, 0);
    check("R9", "valid", valid_o, 0);
    check("R9", "fast", fast_o, 0);
    check("R9", "period", period_o, 0);
    rst_n = 1'b1;
    @(negedge clk_ref);

    // Table walk: R1..R7 (boundaries at 86/87, 129/130, 260/261; R2 warm spacing; R1 pre-high)
    for (int i = 0; i < NVEC; i++) begin
      measure(VECS[i].h, VECS[i].w, VECS[i].pre_hi);
      expect_for(VECS[i].h, ep, ev, ef);
      check("R3", "done", done_o, 1);
      check("R3_R6", "period", period_o, ep);
      check("R4_R5", "valid", valid_o, ev);
      check("R7", "fast", fast_o, ef);
    end

    // R10: result holds while idle
    ep = period_o;
    repeat (300) @(negedge clk_ref);
    check("R10", "period held", period_o, ep);
    check("R10", "done held", done_o, 1);

    // R8: start clears done
    pulse_start();
    check("R8", "done after start", done_o, 0);
    check("R8", "valid after start", valid_o, 0);

    // R8: restart mid-window with a slow wave, then a fast one decides
    wave_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wave_i = 1'b1; repeat (261) @(negedge clk_ref);
      wave_i = 1'b0; repeat (261) @(negedge clk_ref);
    end
    measure(110, 110, 1'b0);
    expect_for(110, ep, ev, ef);
    check("R8", "restart period", period_o, ep);
    check("R8", "restart valid", valid_o, ev);
    check("R8", "restart fast", fast_o, ef);

    finish_run();
  end

endmodule